// File: doc/BRIEF.md
# Pipelined RC6 Cipher Engine

This block runs the RC6 block cipher with 32-bit words, 20 rounds and 128-bit blocks as a fully unrolled pipeline. It can take a new block on every clock cycle. Each block enters with an input valid flag, and the processed block leaves with an output valid flag a fixed number of cycles later. A build-time parameter selects whether an instance encrypts or decrypts. A chip that needs both directions places two instances.

The 44 round keys sit in a register bank. A single-word write port (enable, index, data) loads them. The key schedule is computed elsewhere and loaded before traffic starts. If keys are rewritten while blocks are still inside the pipeline, those blocks come out with undefined contents. Each round takes four pipeline stages: two for the multipliers, one for the rotate-and-mix step and one for the key addition. With one whitening stage at each end, the latency is 82 cycles.

Top module: `rc6_pipe`

## Requirements
- R1: With ENCRYPT=1, out_data equals RC6 encryption of in_data, with words packed as A=[127:96], B=[95:64], C=[63:32], D=[31:0]. First B+=K0 and D+=K1. Then for each round r=1..20: t=rotl(B*(2B+1),5), u=rotl(D*(2D+1),5), A=rotl(A^t,u)+K[2r], C=rotl(C^u,t)+K[2r+1], and (A,B,C,D) becomes (B,C,D,A). Finally A+=K42 and C+=K43. All arithmetic is modulo 2^32, and a rotation uses only the low 5 bits of its amount.
- R2: With ENCRYPT=0, out_data equals RC6 decryption of in_data in the same packing. First C-=K43 and A-=K42. Then for r=20 down to 1: (A,B,C,D) becomes (D,A,B,C), u and t are formed as in R1, C=rotr(C-K[2r+1],t)^u and A=rotr(A-K[2r],u)^t. Finally D-=K1 and B-=K0.
- R3: out_valid equals in_valid delayed by exactly 82 clock cycles, and each result appears 82 cycles after its block was accepted.
- R4: A block is accepted on every cycle where in_valid is high, including back-to-back cycles. Every accepted block produces exactly one result, in the order the blocks arrived, with idle gaps kept.
- R5: A synchronous reset drives out_valid low from the next cycle. No block accepted before the reset ever produces a result.
- R6: A key write with key_addr below 44 replaces key K[key_addr] from the next cycle. A write with key_addr of 44 or above changes no key. Reset clears all keys to zero.
- R7: Feeding the output of an encrypting instance into a decrypting instance loaded with the same keys returns the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key write enable |
| key_addr | input | 6 | Index of the key word to write |
| key_wdata | input | 32 | Key word to write |
| in_valid | input | 1 | Input block valid |
| in_data | input | 128 | Input block {A,B,C,D} |
| out_valid | output | 1 | Output block valid |
| out_data | output | 128 | Output block {A,B,C,D} |

## Verification
The checker assumes that in_valid is low while reset is held. It also assumes the key bank changes only through the write port, so a write is either visible at its index or, when out of range, leaves the bank untouched. The occupancy and latency properties assume keys are never rewritten with blocks in flight. The stimulus therefore writes keys only after both pipelines have drained, with in_valid held low. Random blocks with random idle gaps are mixed with directed all-zero, all-one and sign-bit patterns. A mid-stream reset exercises the flush behaviour.

// File: rtl/rc6_pkg.sv
package rc6_pkg;
  parameter int unsigned WORD_W = 32;
  localparam int unsigned LG_W   = $clog2(WORD_W);
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LG_W-1:0]   shamt_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } blk_t;

  function automatic word_t rotl(input word_t x, input shamt_t n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic word_t rotr(input word_t x, input shamt_t n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} >> n;
    return dbl[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/rc6_fmul.sv
// Two-stage product x*(2x+1) mod 2^WORD_W, built from three half-width partial products.
module rc6_fmul
  import rc6_pkg::*;
(
  input  logic  clk,
  input  word_t x,
  output word_t p
);
  word_t y;
  logic [WORD_W-1:0] ll_q;
  logic [HALF_W-1:0] lh_q;
  logic [HALF_W-1:0] hl_q;

  assign y = {x[WORD_W-2:0], 1'b1};

  always_ff @(posedge clk) begin
    ll_q <= WORD_W'(x[HALF_W-1:0]) * WORD_W'(y[HALF_W-1:0]);
    lh_q <= x[HALF_W-1:0] * y[WORD_W-1:HALF_W];
    hl_q <= x[WORD_W-1:HALF_W] * y[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    p <= ll_q + {lh_q + hl_q, {HALF_W{1'b0}}};
  end
endmodule

// File: rtl/rc6_whiten.sv
// One registered stage adding or subtracting two keys on the A/C or the B/D word pair.
module rc6_whiten
  import rc6_pkg::*;
#(
  parameter bit SUB   = 1'b0,
  parameter bit ON_AC = 1'b0
) (
  input  logic  clk,
  input  blk_t  blk_i,
  input  word_t kx,
  input  word_t ky,
  output blk_t  blk_o
);
  blk_t nxt;

  always_comb begin
    nxt = blk_i;
    if (ON_AC) begin
      nxt.a = SUB ? blk_i.a - kx : blk_i.a + kx;
      nxt.c = SUB ? blk_i.c - ky : blk_i.c + ky;
    end else begin
      nxt.b = SUB ? blk_i.b - kx : blk_i.b + kx;
      nxt.d = SUB ? blk_i.d - ky : blk_i.d + ky;
    end
  end

  always_ff @(posedge clk) begin
    blk_o <= nxt;
  end
endmodule

// File: rtl/rc6_round.sv
// One cipher round over four stages: two multiplier stages, a mix stage and a key/rotate stage.
module rc6_round
  import rc6_pkg::*;
#(
  parameter bit ENCRYPT = 1'b1
) (
  input  logic  clk,
  input  blk_t  blk_i,
  input  word_t k_lo,
  input  word_t k_hi,
  output blk_t  blk_o
);
  blk_t  s_in;
  blk_t  h1_q, h2_q;
  word_t pb, pd;
  word_t t_w, u_w;
  word_t xa_n, xc_n;
  word_t xa_q, xc_q, t_q, u_q, b3_q, d3_q;
  blk_t  res_n;

  generate
    if (ENCRYPT) begin : g_in_enc
      assign s_in = blk_i;
    end else begin : g_in_dec
      assign s_in = '{a: blk_i.d, b: blk_i.a, c: blk_i.b, d: blk_i.c};
    end
  endgenerate

  rc6_fmul u_mul_b (.clk(clk), .x(s_in.b), .p(pb));
  rc6_fmul u_mul_d (.clk(clk), .x(s_in.d), .p(pd));

  always_ff @(posedge clk) begin
    h1_q <= s_in;
    h2_q <= h1_q;
  end

  assign t_w = rotl(pb, shamt_t'(LG_W));
  assign u_w = rotl(pd, shamt_t'(LG_W));

  generate
    if (ENCRYPT) begin : g_mix_enc
      assign xa_n = h2_q.a ^ t_w;
      assign xc_n = h2_q.c ^ u_w;
      always_comb begin
        res_n.a = b3_q;
        res_n.b = rotl(xc_q, t_q[LG_W-1:0]) + k_hi;
        res_n.c = d3_q;
        res_n.d = rotl(xa_q, u_q[LG_W-1:0]) + k_lo;
      end
    end else begin : g_mix_dec
      assign xa_n = h2_q.a - k_lo;
      assign xc_n = h2_q.c - k_hi;
      always_comb begin
        res_n.a = rotr(xa_q, u_q[LG_W-1:0]) ^ t_q;
        res_n.b = b3_q;
        res_n.c = rotr(xc_q, t_q[LG_W-1:0]) ^ u_q;
        res_n.d = d3_q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    xa_q  <= xa_n;
    xc_q  <= xc_n;
    t_q   <= t_w;
    u_q   <= u_w;
    b3_q  <= h2_q.b;
    d3_q  <= h2_q.d;
    blk_o <= res_n;
  end
endmodule

// File: rtl/rc6_keyfile.sv
// Round key bank: every word readable in parallel, one word written per cycle.
module rc6_keyfile
  import rc6_pkg::*;
#(
  parameter int unsigned NUM_KEYS = 44,
  parameter int unsigned KADDR_W  = $clog2(NUM_KEYS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [KADDR_W-1:0]              addr,
  input  word_t                           wdata,
  output logic [NUM_KEYS-1:0][WORD_W-1:0] keys
);
  always_ff @(posedge clk) begin
    if (rst) begin
      keys <= '0;
    end else begin
      for (int i = 0; i < NUM_KEYS; i++) begin
        if (we && (addr == KADDR_W'(i))) keys[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/rc6_pipe.sv
module rc6_pipe
  import rc6_pkg::*;
#(
  parameter bit          ENCRYPT    = 1'b1,
  parameter int unsigned NUM_ROUNDS = 20,
  localparam int unsigned NUM_KEYS  = 2 * NUM_ROUNDS + 4,
  localparam int unsigned KADDR_W   = $clog2(NUM_KEYS),
  localparam int unsigned BLK_W     = 4 * WORD_W,
  localparam int unsigned LATENCY   = 4 * NUM_ROUNDS + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_we,
  input  logic [KADDR_W-1:0] key_addr,
  input  logic [WORD_W-1:0]  key_wdata,
  input  logic               in_valid,
  input  logic [BLK_W-1:0]   in_data,
  output logic               out_valid,
  output logic [BLK_W-1:0]   out_data
);
  logic [NUM_KEYS-1:0][WORD_W-1:0] key_bank;
  blk_t chain [0:NUM_ROUNDS];
  blk_t post_q;
  logic [LATENCY-1:0] vpipe;

  rc6_keyfile #(.NUM_KEYS(NUM_KEYS), .KADDR_W(KADDR_W)) u_keys (
    .clk(clk), .rst(rst), .we(key_we), .addr(key_addr),
    .wdata(key_wdata), .keys(key_bank)
  );

  rc6_whiten #(.SUB(!ENCRYPT), .ON_AC(!ENCRYPT)) u_pre (
    .clk(clk),
    .blk_i(blk_t'(in_data)),
    .kx(ENCRYPT ? key_bank[0] : key_bank[NUM_KEYS-2]),
    .ky(ENCRYPT ? key_bank[1] : key_bank[NUM_KEYS-1]),
    .blk_o(chain[0])
  );

  for (genvar g = 0; g < NUM_ROUNDS; g++) begin : g_round
    localparam int unsigned RIDX = ENCRYPT ? g + 1 : NUM_ROUNDS - g;
    rc6_round #(.ENCRYPT(ENCRYPT)) u_rnd (
      .clk(clk),
      .blk_i(chain[g]),
      .k_lo(key_bank[2*RIDX]),
      .k_hi(key_bank[2*RIDX+1]),
      .blk_o(chain[g+1])
    );
  end

  rc6_whiten #(.SUB(!ENCRYPT), .ON_AC(ENCRYPT)) u_post (
    .clk(clk),
    .blk_i(chain[NUM_ROUNDS]),
    .kx(ENCRYPT ? key_bank[NUM_KEYS-2] : key_bank[0]),
    .ky(ENCRYPT ? key_bank[NUM_KEYS-1] : key_bank[1]),
    .blk_o(post_q)
  );

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LATENCY-2:0], in_valid};
  end

  assign out_valid = vpipe[LATENCY-1];
  assign out_data  = post_q;
endmodule

// File: rtl/rc6_pipe_chk.sv
module rc6_pipe_chk
  import rc6_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS = 20,
  localparam int unsigned NUM_KEYS  = 2 * NUM_ROUNDS + 4,
  localparam int unsigned KADDR_W   = $clog2(NUM_KEYS),
  localparam int unsigned LAT       = 4 * NUM_ROUNDS + 2
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            key_we,
  input logic [KADDR_W-1:0]              key_addr,
  input logic [WORD_W-1:0]               key_wdata,
  input logic                            in_valid,
  input logic                            out_valid,
  input logic [NUM_KEYS-1:0][WORD_W-1:0] keys
);
  int unsigned since_rst;
  int unsigned inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= 0;
      inflight  <= 0;
    end else begin
      if (since_rst < LAT) since_rst <= since_rst + 1;
      inflight <= inflight + int'(in_valid) - int'(out_valid);
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R5
  AST_OUT_LATE: assert property (@(posedge clk) disable iff (rst) out_valid |-> since_rst >= LAT); // R3
  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (rst) inflight <= LAT); // R4
  AST_NO_ORPHAN: assert property (@(posedge clk) disable iff (rst) out_valid |-> inflight > 0); // R4
  AST_KEY_WRITE: assert property (@(posedge clk) disable iff (rst) (key_we && key_addr < NUM_KEYS) |=> keys[$past(key_addr)] == $past(key_wdata)); // R6
  AST_KEY_IGNORE: assert property (@(posedge clk) disable iff (rst) (key_we && key_addr >= NUM_KEYS) |=> $stable(keys)); // R6
endmodule

bind rc6_pipe rc6_pipe_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk(clk), .rst(rst), .key_we(key_we), .key_addr(key_addr),
  .key_wdata(key_wdata), .in_valid(in_valid), .out_valid(out_valid),
  .keys(key_bank)
);

// File: tb/rc6_pipe_test.sv
module rc6_pipe_test;
  localparam int LAT = 82;

  logic         clk = 1'b0;
  logic         rst;
  logic         key_we;
  logic [5:0]   key_addr;
  logic [31:0]  key_wdata;
  logic         in_valid;
  logic [127:0] in_data;
  logic         e_valid, d_valid;
  logic [127:0] e_data, d_data;

  logic [31:0]  bk [0:43];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int e_seen = 0;
  logic [127:0] pt_q[$];
  int           t_q[$];
  logic [127:0] pt2_q[$];
  logic [127:0] ct2_q[$];
  int           t2_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rc6_pipe #(.ENCRYPT(1'b1)) uut (
    .clk(clk), .rst(rst), .key_we(key_we), .key_addr(key_addr),
    .key_wdata(key_wdata), .in_valid(in_valid), .in_data(in_data),
    .out_valid(e_valid), .out_data(e_data)
  );

  rc6_pipe #(.ENCRYPT(1'b0)) uut_dec (
    .clk(clk), .rst(rst), .key_we(key_we), .key_addr(key_addr),
    .key_wdata(key_wdata), .in_valid(e_valid), .in_data(e_data),
    .out_valid(d_valid), .out_data(d_data)
  );

  function automatic logic [31:0] rl(logic [31:0] x, logic [4:0] n);
    return (n == 0) ? x : ((x << n) | (x >> (6'd32 - n)));
  endfunction

  function automatic logic [31:0] rr(logic [31:0] x, logic [4:0] n);
    return (n == 0) ? x : ((x >> n) | (x << (6'd32 - n)));
  endfunction

  function automatic logic [127:0] enc_ref(logic [127:0] p);
    logic [31:0] a, b, c, d, t, u, tmp;
    {a, b, c, d} = p;
    b = b + bk[0];
    d = d + bk[1];
    for (int i = 1; i <= 20; i++) begin
      t = rl(b * (b + b + 32'd1), 5);
      u = rl(d * (d + d + 32'd1), 5);
      a = rl(a ^ t, u[4:0]) + bk[2*i];
      c = rl(c ^ u, t[4:0]) + bk[2*i+1];
      tmp = a; a = b; b = c; c = d; d = tmp;
    end
    a = a + bk[42];
    c = c + bk[43];
    return {a, b, c, d};
  endfunction

  function automatic logic [127:0] dec_ref(logic [127:0] p);
    logic [31:0] a, b, c, d, t, u, tmp;
    {a, b, c, d} = p;
    c = c - bk[43];
    a = a - bk[42];
    for (int i = 20; i >= 1; i--) begin
      tmp = d; d = c; c = b; b = a; a = tmp;
      u = rl(d * (d + d + 32'd1), 5);
      t = rl(b * (b + b + 32'd1), 5);
      c = rr(c - bk[2*i+1], t[4:0]) ^ u;
      a = rr(a - bk[2*i], u[4:0]) ^ t;
    end
    d = d - bk[1];
    b = b - bk[0];
    return {a, b, c, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_key(input logic [5:0] addr, input logic [31:0] data);
    key_we = 1'b1;
    key_addr = addr;
    key_wdata = data;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic send(input logic [127:0] blk);
    in_valid = 1'b1;
    in_data = blk;
    pt_q.push_back(blk);
    t_q.push_back(cyc);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Output monitor, sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    if (e_valid) begin
      e_seen++;
      if (pt_q.size() == 0) begin
        check(1'b0, "R4 unexpected encrypt output", e_data, '0);
      end else begin
        logic [127:0] pt, ct;
        int t0;
        pt = pt_q.pop_front();
        t0 = t_q.pop_front();
        ct = enc_ref(pt);
        check(e_data === ct, "R1 ciphertext", e_data, ct);
        check(cyc - t0 == LAT, "R3 encrypt latency", 128'(cyc - t0), 128'(LAT));
        pt2_q.push_back(pt);
        ct2_q.push_back(ct);
        t2_q.push_back(cyc);
      end
    end
    if (d_valid) begin
      if (pt2_q.size() == 0) begin
        check(1'b0, "R4 unexpected decrypt output", d_data, '0);
      end else begin
        logic [127:0] pt, ct, dx;
        int t0;
        pt = pt2_q.pop_front();
        ct = ct2_q.pop_front();
        t0 = t2_q.pop_front();
        dx = dec_ref(ct);
        check(d_data === dx, "R2 decryption", d_data, dx);
        check(d_data === pt, "R7 round trip", d_data, pt);
        check(cyc - t0 == LAT, "R3 decrypt latency", 128'(cyc - t0), 128'(LAT));
      end
    end
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    int snap;
    seed_dummy = $urandom(32'h5EED_0C6);
    rst = 1'b1; key_we = 1'b0; key_addr = '0; key_wdata = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check(!e_valid && !d_valid, "R5 valid low in reset", {e_valid, d_valid}, '0);
    rst = 1'b0;

    // R6: load every key, then write out-of-range indices that must not land anywhere
    for (int k = 0; k < 44; k++) begin
      bk[k] = $urandom;
      write_key(6'(k), bk[k]);
    end
    write_key(6'd44, 32'hDEAD_BEEF);
    write_key(6'd63, 32'hFFFF_FFFF);
    idle(2);

    // Directed corner blocks, back to back (R1, R4)
    send('0);
    send({128{1'b1}});
    send({32'h8000_0000, 32'h0, 32'h0, 32'h1});
    send({4{32'h8000_0001}});
    // Random blocks with random gaps (R1, R3, R4)
    for (int n = 0; n < 200; n++) begin
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      send({$urandom, $urandom, $urandom, $urandom});
    end
    idle(200);
    check(pt_q.size() == 0 && pt2_q.size() == 0, "R4 all blocks returned",
          128'(pt_q.size() + pt2_q.size()), '0);

    // R6: rewrite some keys with the pipeline empty
    bk[7] = $urandom;  write_key(6'd7, bk[7]);
    bk[42] = $urandom; write_key(6'd42, bk[42]);
    bk[0] = 32'hFFFF_FFFF; write_key(6'd0, bk[0]);
    write_key(6'd50, 32'h1234_5678);
    idle(2);
    for (int n = 0; n < 30; n++) send({$urandom, $urandom, $urandom, $urandom});
    idle(200);
    check(pt_q.size() == 0 && pt2_q.size() == 0, "R6 blocks after key update returned",
          128'(pt_q.size() + pt2_q.size()), '0);

    // R5: reset with blocks in flight; none may come out
    for (int n = 0; n < 10; n++) send({$urandom, $urandom, $urandom, $urandom});
    idle(20);
    rst = 1'b1;
    pt_q.delete(); t_q.delete();
    pt2_q.delete(); ct2_q.delete(); t2_q.delete();
    snap = e_seen;
    idle(2);
    rst = 1'b0;
    idle(120);
    check(e_seen == snap && !d_valid, "R5 flushed blocks never appear",
          128'(e_seen - snap), '0);

    // R6: reset cleared the keys, so the engine now runs with all-zero keys
    for (int k = 0; k < 44; k++) bk[k] = '0;
    send({32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210});
    send('0);
    idle(200);
    check(pt_q.size() == 0 && pt2_q.size() == 0, "R6 zero-key blocks returned",
          128'(pt_q.size() + pt2_q.size()), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule